// File: doc/BRIEF.md
# UART Frame End-of-Frame Detector

This block sits beside a UART receiver and finds the boundaries of multi-byte frames. A frame has no in-band delimiter. It ends when the receive line stays high for a programmable number of bit periods. The block is driven by the receiver's bit-period strobe, the sampled receive level and the receiver's byte-complete pulse. It does not deserialise data, generate baud timing or buffer anything.

Two outputs come out of it:

- A one-clock end-of-frame pulse. It fires once the idle gap after the last stop bit reaches the programmed length. The pulse is only produced if at least one byte arrived since the previous end of frame, so a quiet line never raises it.
- A transmit-permit flag. It drops at the first start bit of a frame and comes back only after a further fixed guard of 5 idle bit periods. This guard keeps the peer from racing the end-of-frame decision with its next frame.

The idle length is captured from its input only while the transmit-permit flag is high. A frame in progress therefore always uses one consistent length.

Top module: `uart_eof_detector`

## Requirements
- R1: After synchronous reset, `eof_pulse` is 0 and `tx_permit` is 1.
- R2: A bit strobe with `rx_line`=1 counts as an idle period only when no byte is open. A byte opens at its start bit and closes at `byte_done`; the strobe that arrives in the same cycle as `byte_done` is not counted. `eof_pulse` goes high for exactly one clock, in the cycle after the strobe that completes the programmed number of consecutive idle periods.
- R3: An idle gap shorter than the programmed length keeps the frame open. No pulse is produced, and the low sample that begins the next byte restarts the idle count from zero.
- R4: No `eof_pulse` is produced unless at least one `byte_done` has occurred since reset or since the previous `eof_pulse`, however long the line stays idle.
- R5: A bit strobe with `rx_line`=0 while no byte is open is a start bit. `tx_permit` is 0 from the next cycle on.
- R6: `tx_permit` returns to 1 in the cycle after the strobe that completes (programmed length + 5) consecutive idle periods. It stays 0 for every earlier idle strobe.
- R7: `eof_len` is captured only in cycles where `tx_permit` is 1. This includes the cycle of the start-bit strobe. Changes while `tx_permit` is 0 have no effect on the running frame. A captured value of 0 acts as 1.
- R8: When a start-bit strobe arrives exactly where the idle strobe completing the programmed length would have been, the count is cleared, no `eof_pulse` is produced, and the frame continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-clock strobe at each bit-sampling point |
| rx_line | input | 1 | Sampled receive line level, valid with `bit_tick` |
| byte_done | input | 1 | One-clock pulse from the receiver at the stop bit of a byte |
| eof_len | input | LEN_W | Idle periods that end a frame |
| eof_pulse | output | 1 | One-clock end-of-frame indication |
| tx_permit | output | 1 | High when the peer may start a new frame |

## Verification
The critical coincidence is a start bit falling on the very strobe that would complete the idle count. Clearing the counter and raising the end-of-frame pulse then compete in one cycle. The bench provokes this by sending a byte, waiting exactly one idle period fewer than the programmed length, and then sending the next byte. Its start bit thus lands on the completing strobe. The outcome is judged every clock against a behavioural model, and then by the pulse total: no pulse at the collision, one pulse after the later full gap. A second pairing is the stop-bit strobe that coincides with `byte_done`. The exact pulse timing after each gap shows whether that strobe was wrongly counted.

// File: rtl/uart_eof_pkg.sv
package uart_eof_pkg;
  // Extra idle bit periods after end of frame before the peer may transmit.
  localparam int unsigned GUARD_BITS = 5;
endpackage

// File: rtl/eof_len_latch.sv
module eof_len_latch #(
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned DEF_LEN = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [LEN_W-1:0] len_in,
  output logic [LEN_W-1:0] len_q
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= LEN_W'(DEF_LEN);
    end else if (load_en) begin
      len_q <= (len_in == '0) ? ONE : len_in;
    end
  end

  // R7: value frozen while a frame or its guard is running
  assert_len_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(len_q));

  // R7: zero is never used as a length
  assert_len_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    len_q != '0);
endmodule

// File: rtl/eof_idle_counter.sv
module eof_idle_counter
  import uart_eof_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rx,
  input  logic             in_byte,
  input  logic [LEN_W-1:0] len,
  output logic             hit_eof,
  output logic             hit_guard
);
  localparam int unsigned CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] eof_at;
  logic             step;
  logic             clear;

  assign limit  = {1'b0, len} + CNT_W'(GUARD_BITS);
  assign eof_at = {1'b0, len} - CNT_W'(1);
  assign clear  = tick & ~rx;
  assign step   = tick & rx & ~in_byte & (cnt_q < limit);

  assign hit_eof   = step & (cnt_q == eof_at);
  assign hit_guard = step & (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R3: any low sample restarts the idle count
  assert_zero_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !rx) |=> (cnt_q == '0));

  // R2: no idle counting while a byte is open
  assert_no_count_in_byte_R2: assert property (@(posedge clk) disable iff (rst)
    (in_byte && !(tick && !rx)) |=> $stable(cnt_q));
endmodule

// File: rtl/eof_frame_tracker.sv
module eof_frame_tracker (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rx,
  input  logic byte_done,
  input  logic hit_eof,
  input  logic hit_guard,
  output logic in_byte,
  output logic eof_pulse,
  output logic tx_permit
);
  logic start;
  logic byte_seen;

  assign start = tick & ~rx & ~in_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_byte   <= 1'b0;
      byte_seen <= 1'b0;
      eof_pulse <= 1'b0;
      tx_permit <= 1'b1;
    end else begin
      if (start)          in_byte <= 1'b1;
      else if (byte_done) in_byte <= 1'b0;

      if (byte_done)    byte_seen <= 1'b1;
      else if (hit_eof) byte_seen <= 1'b0;

      eof_pulse <= hit_eof & byte_seen;

      if (start)          tx_permit <= 1'b0;
      else if (hit_guard) tx_permit <= 1'b1;
    end
  end

  // R2: the end-of-frame pulse is one clock wide
  assert_eof_single_R2: assert property (@(posedge clk) disable iff (rst)
    eof_pulse |=> !eof_pulse);

  // R5: a start bit withdraws transmit permission
  assert_start_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !rx && !in_byte) |=> !tx_permit);

  // R2: a pulse never appears while a byte is open
  assert_eof_outside_byte_R2: assert property (@(posedge clk) disable iff (rst)
    eof_pulse |-> !in_byte);
endmodule

// File: rtl/uart_eof_detector.sv
module uart_eof_detector #(
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned DEF_LEN = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_tick,
  input  logic             rx_line,
  input  logic             byte_done,
  input  logic [LEN_W-1:0] eof_len,
  output logic             eof_pulse,
  output logic             tx_permit
);
  logic [LEN_W-1:0] len_q;
  logic             in_byte;
  logic             hit_eof;
  logic             hit_guard;

  eof_len_latch #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN)) u_len (
    .clk     (clk),
    .rst     (rst),
    .load_en (tx_permit),
    .len_in  (eof_len),
    .len_q   (len_q)
  );

  eof_idle_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (bit_tick),
    .rx        (rx_line),
    .in_byte   (in_byte),
    .len       (len_q),
    .hit_eof   (hit_eof),
    .hit_guard (hit_guard)
  );

  eof_frame_tracker u_trk (
    .clk       (clk),
    .rst       (rst),
    .tick      (bit_tick),
    .rx        (rx_line),
    .byte_done (byte_done),
    .hit_eof   (hit_eof),
    .hit_guard (hit_guard),
    .in_byte   (in_byte),
    .eof_pulse (eof_pulse),
    .tx_permit (tx_permit)
  );

  // R6: permission only returns right after an idle strobe
  assert_permit_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_permit) |-> $past(bit_tick && rx_line));

  // R3: an end-of-frame pulse is always preceded by an idle strobe
  assert_eof_after_idle_R3: assert property (@(posedge clk) disable iff (rst)
    eof_pulse |-> $past(bit_tick && rx_line));
endmodule

// File: tb/uart_eof_detector_tb.sv
module uart_eof_detector_tb;
  localparam int LEN_W = 8;
  localparam int GUARD = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b0;
  logic rx_line = 1'b1;
  logic byte_done = 1'b0;
  logic [LEN_W-1:0] eof_len = 8'd10;
  logic eof_pulse;
  logic tx_permit;

  int checks = 0;
  int fails = 0;
  int eofs = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  int  m_idle = 0;
  int  m_len = 10;
  bit  m_open = 1'b0;
  bit  m_got = 1'b0;
  bit  m_eof = 1'b0;
  bit  m_permit = 1'b1;

  always #10 clk = ~clk;

  uart_eof_detector #(.LEN_W(LEN_W), .DEF_LEN(10)) u_dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_line(rx_line),
    .byte_done(byte_done), .eof_len(eof_len),
    .eof_pulse(eof_pulse), .tx_permit(tx_permit)
  );

  // Behavioural reference, evaluated on the inputs present at each edge
  always @(posedge clk) begin
    if (rst) begin
      m_idle = 0; m_len = 10; m_open = 0; m_got = 0; m_eof = 0; m_permit = 1;
    end else begin
      bit eof_now;
      bit start_now;
      bit old_permit;
      int lim;
      eof_now = 0; start_now = 0;
      old_permit = m_permit;
      lim = m_len + GUARD;
      if (bit_tick && !rx_line) begin
        m_idle = 0;
        if (!m_open) begin start_now = 1; m_open = 1; m_permit = 0; end
      end else if (bit_tick && rx_line && !m_open && m_idle < lim) begin
        m_idle++;
        if (m_idle == m_len && m_got) begin eof_now = 1; m_got = 0; end
        if (m_idle == lim) m_permit = 1;
      end
      if (byte_done) begin
        m_got = 1;
        if (!start_now) m_open = 0;
      end
      m_eof = eof_now;
      if (old_permit) m_len = (eof_len == 0) ? 1 : int'(eof_len);
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (eof_pulse !== m_eof || tx_permit !== m_permit) begin
        fails++;
        $display("FAIL %s: eof_pulse=%0b tx_permit=%0b expected %0b %0b at %0t",
                 cur_req, eof_pulse, tx_permit, m_eof, m_permit, $time);
      end
      if (eof_pulse === 1'b1) eofs++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic b);
    @(negedge clk);
    bit_tick = 1'b1; rx_line = r; byte_done = b;
    @(negedge clk);
    bit_tick = 1'b0; byte_done = 1'b0; rx_line = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d);
    step(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) step(d[i], 1'b0);
    step(1'b1, 1'b1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 eof_pulse", eof_pulse, 0);
    check("R1 tx_permit", tx_permit, 1);

    // Two bytes with a sub-threshold gap, then a full gap and the guard
    cur_req = "R5";
    send_byte(8'h00);
    check("R5 permit after start", tx_permit, 0);
    cur_req = "R3";
    idle(9);
    send_byte(8'h55);
    idle(9);
    check("R3 short gap keeps frame", eofs, 0);
    cur_req = "R2";
    idle(1);
    check("R2 eof after full gap", eofs, 1);
    cur_req = "R6";
    idle(4);
    check("R6 permit held in guard", tx_permit, 0);
    idle(1);
    check("R6 permit after guard", tx_permit, 1);

    // Quiet line without bytes
    cur_req = "R4";
    idle(30);
    check("R4 no eof on idle line", eofs, 1);

    // Start bit on the strobe that would complete the gap
    cur_req = "R8";
    send_byte(8'hA5);
    idle(9);
    send_byte(8'h0F);
    check("R8 collision gives no eof", eofs, 1);
    idle(10);
    check("R8 eof after later gap", eofs, 2);
    idle(GUARD);

    // Length capture rules
    cur_req = "R7";
    eof_len = 8'd20;
    @(negedge clk);
    send_byte(8'h3C);
    eof_len = 8'd3;
    idle(3);
    check("R7 length change ignored mid-frame", eofs, 2);
    idle(17);
    check("R7 captured length used", eofs, 3);
    idle(GUARD);
    eof_len = 8'd0;
    @(negedge clk);
    send_byte(8'hFF);
    idle(1);
    check("R7 zero length acts as one", eofs, 4);
    idle(GUARD);
    check("R6 permit restored", tx_permit, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule